// File: doc/BRIEF.md
# Serial Adapter Bus Register Interface

This block is the host-facing register window of a serial interface adapter. It is a Wishbone classic slave with a 16-bit data path and eight word registers, addressed by a 3-bit word index (byte offset divided by two). Behind it sit the receive and transmit FIFOs, the serial engines and the baud counter, none of which are part of this block. The block passes their settings out on dedicated configuration pins. It reads their FIFO flags in as status, and it moves data words between the bus and the FIFOs.

A host programs the frame shape and clocking at word 0, the 20-bit baud divisor at words 6 and 7, and the interrupt mask at word 2. It then moves characters through the shared data port at word 3. A read of that port takes a word from the receive FIFO, and a write to it hands a word to the transmit FIFO. The status word at word 1 carries positive-sense "not empty" and "not full" flags where a host usually wants them. It also carries a summary bit that is set when any of the flags is set. One level-sensitive interrupt request combines the flags with the mask.

Top module: `serial_csr`

## Requirements
- R1: Every access is acknowledged by `wb_ack_o` high for exactly one clock. Ack rises on the clock edge after the first edge at which `wb_cyc_i` and `wb_stb_i` are both high. It is never high on two consecutive cycles, even when strobe is held.
- R2: Word 0 is read/write. Bits 4:0 set `frame_len_o`, bit 8 sets `rxc_edge_en_o`, bit 9 sets `rxd_edge_en_o`, bits 12:10 set `txc_mode_o`, and bit 13 sets `rxc_pol_o`. All other bits read back as zero. The outputs change only at an acknowledged write.
- R3: Word 1 is read-only status. Bit 0 is receive FIFO not empty, bit 1 is receive FIFO full, bit 2 is transmit FIFO empty, and bit 3 is transmit FIFO not full. Each bit copies `fifo_flags_i` bit of the same index, sampled at the edge that raises ack. Bits 14:4 read zero.
- R4: Status bit 15 reads one exactly when any of status bits 3:0 reads one.
- R5: Word 2 is a read/write interrupt mask whose bits 3:0 line up with status bits 3:0. Bits 15:4 read zero.
- R6: `irq_o` is high exactly when some bit is set in both `fifo_flags_i` and the mask. It follows the flags without a clock delay.
- R7: A read of word 3 returns `rx_data_i`, sampled at the edge that raises ack. It pulses `rx_pop_o` during the ack cycle only, so there is one pop for each acknowledged read.
- R8: A write to word 3 presents the written word on `tx_data_o` and pulses `tx_push_o` during the ack cycle only. Configuration, mask and divisor are not changed.
- R9: Words 4 and 5 read as zero, and writes to them change nothing readable or driven.
- R10: Word 6 holds divisor bits 15:0. Bits 3:0 of word 7 hold divisor bits 19:16, and bits 15:4 of word 7 read zero. `divisor_o` changes only at an acknowledged write.
- R11: Reset clears configuration, mask and divisor to zero and holds ack, pop and push low.
- R12: A write to the status word has no effect. Accesses to any word other than 3 never pulse `rx_pop_o` or `tx_push_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word index (byte offset / 2) |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| fifo_flags_i | input | 4 | {tx not full, tx empty, rx full, rx not empty} |
| rx_data_i | input | 16 | Head word of receive FIFO |
| rx_pop_o | output | 1 | Pop receive FIFO |
| tx_data_o | output | 16 | Word for transmit FIFO |
| tx_push_o | output | 1 | Push transmit FIFO |
| frame_len_o | output | 5 | Frame length in bits |
| rxc_edge_en_o | output | 1 | Receive clock edge detection enable |
| rxd_edge_en_o | output | 1 | Receive data edge detection enable |
| txc_mode_o | output | 3 | Transmit clock mode |
| rxc_pol_o | output | 1 | Receive clock polarity |
| divisor_o | output | 20 | Baud divisor |
| irq_o | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach from the ports is a master that keeps strobe high past the acknowledge on the data port. Here a careless design pops the receive FIFO twice for one logical read. The bench holds strobe for a second clock on both a read and a write of word 3. It checks that ack and the pop or push appear only in the first cycle. A second case is a write aimed at read-only or unused words. The bench follows it by reading back every word, and on every clock it compares all configuration pins against its own model.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 3;
    localparam int FLAG_W = 4;

    // word index decode; index = byte offset / 2
    typedef enum logic [IDX_W-1:0] {
        IDX_CFG   = 3'd0,
        IDX_STAT  = 3'd1,
        IDX_MASK  = 3'd2,
        IDX_DATA  = 3'd3,
        IDX_RSV0  = 3'd4,
        IDX_RSV1  = 3'd5,
        IDX_DIVLO = 3'd6,
        IDX_DIVHI = 3'd7
    } reg_idx_e;

    // bit positions inside the configuration word
    localparam int CF_LEN_LSB = 0;
    localparam int CF_LEN_W   = 5;
    localparam int CF_RXCE    = 8;
    localparam int CF_RXDE    = 9;
    localparam int CF_TXM_LSB = 10;
    localparam int CF_TXM_W   = 3;
    localparam int CF_RXCP    = 13;

    typedef struct packed {
        logic                rxc_pol;
        logic [CF_TXM_W-1:0] txc_mode;
        logic                rxd_edge_en;
        logic                rxc_edge_en;
        logic [CF_LEN_W-1:0] frame_len;
    } cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CF_LEN_LSB +: CF_LEN_W] = c.frame_len;
        w[CF_RXCE]                = c.rxc_edge_en;
        w[CF_RXDE]                = c.rxd_edge_en;
        w[CF_TXM_LSB +: CF_TXM_W] = c.txc_mode;
        w[CF_RXCP]                = c.rxc_pol;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(logic [WORD_W-1:0] w);
        cfg_t c;
        c.frame_len   = w[CF_LEN_LSB +: CF_LEN_W];
        c.rxc_edge_en = w[CF_RXCE];
        c.rxd_edge_en = w[CF_RXDE];
        c.txc_mode    = w[CF_TXM_LSB +: CF_TXM_W];
        c.rxc_pol     = w[CF_RXCP];
        return c;
    endfunction

endpackage

// File: rtl/serial_csr_bus.sv
module serial_csr_bus (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cyc_i,
    input  logic stb_i,
    output logic take_o,
    output logic ack_o
);

    typedef struct packed {
        logic ack;
    } bus_st_t;

    bus_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        // a request is taken only when no ack is outstanding
        take_o = cyc_i && stb_i && !s_q.ack;
        s_d.ack = take_o;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign ack_o = s_q.ack;

    AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |=> !ack_o); // R1
    AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ack_o) |-> $past(cyc_i && stb_i)); // R1

endmodule

// File: rtl/serial_csr_file.sv
module serial_csr_file
    import serial_csr_pkg::*;
#(
    parameter int DIV_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output cfg_t              cfg_o,
    output logic [FLAG_W-1:0] mask_o,
    output logic [DIV_W-1:0]  div_o
);

    localparam int DIV_HI_W = DIV_W - WORD_W;

    typedef struct packed {
        cfg_t              cfg;
        logic [FLAG_W-1:0] mask;
        logic [DIV_W-1:0]  div;
    } file_st_t;

    file_st_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr_i) begin
            case (idx_i)
                IDX_CFG:   f_d.cfg  = word_to_cfg(wdata_i);
                IDX_MASK:  f_d.mask = wdata_i[FLAG_W-1:0];
                IDX_DIVLO: f_d.div[WORD_W-1:0] = wdata_i;
                IDX_DIVHI: f_d.div[DIV_W-1:WORD_W] = wdata_i[DIV_HI_W-1:0];
                default:   f_d = f_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) f_q <= '0;
        else       f_q <= f_d;
    end

    assign cfg_o  = f_q.cfg;
    assign mask_o = f_q.mask;
    assign div_o  = f_q.div;

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_i |=> $stable(mask_o)); // R5

endmodule

// File: rtl/serial_csr_status.sv
module serial_csr_status
    import serial_csr_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] mask_i,
    output logic [WORD_W-1:0] stat_o,
    output logic              irq_o
);

    logic [FLAG_W-1:0] masked;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_mask
        assign masked[g] = flags_i[g] & mask_i[g];
    end

    always_comb begin
        stat_o             = '0;
        stat_o[FLAG_W-1:0] = flags_i;
        stat_o[WORD_W-1]   = |flags_i;
        irq_o              = |masked;
    end

    always_comb begin
        AST_IRQ_NEEDS_MASK: assert (!irq_o || (mask_i != '0)); // R6
    end

endmodule

// File: rtl/serial_csr.sv
module serial_csr
    import serial_csr_pkg::*;
#(
    parameter int DIV_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [2:0]        wb_adr_i,
    input  logic [15:0]       wb_dat_i,
    output logic [15:0]       wb_dat_o,
    output logic              wb_ack_o,
    input  logic [3:0]        fifo_flags_i,
    input  logic [15:0]       rx_data_i,
    output logic              rx_pop_o,
    output logic [15:0]       tx_data_o,
    output logic              tx_push_o,
    output logic [4:0]        frame_len_o,
    output logic              rxc_edge_en_o,
    output logic              rxd_edge_en_o,
    output logic [2:0]        txc_mode_o,
    output logic              rxc_pol_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic              irq_o
);

    localparam int DIV_HI_W = DIV_W - WORD_W;

    logic              take;
    logic              wr_en;
    cfg_t              cfg;
    logic [FLAG_W-1:0] mask;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] div_hi_word;
    logic [WORD_W-1:0] rmux;

    serial_csr_bus u_bus (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cyc_i  (wb_cyc_i),
        .stb_i  (wb_stb_i),
        .take_o (take),
        .ack_o  (wb_ack_o)
    );

    assign wr_en = take && wb_we_i;

    serial_csr_file #(.DIV_W(DIV_W)) u_file (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (wr_en),
        .idx_i   (wb_adr_i),
        .wdata_i (wb_dat_i),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .div_o   (divisor_o)
    );

    serial_csr_status u_status (
        .flags_i (fifo_flags_i),
        .mask_i  (mask),
        .stat_o  (stat_word),
        .irq_o   (irq_o)
    );

    always_comb begin
        div_hi_word                 = '0;
        div_hi_word[DIV_HI_W-1:0]   = divisor_o[DIV_W-1:WORD_W];
    end

    always_comb begin
        case (wb_adr_i)
            IDX_CFG:   rmux = cfg_to_word(cfg);
            IDX_STAT:  rmux = stat_word;
            IDX_MASK:  rmux = {{(WORD_W-FLAG_W){1'b0}}, mask};
            IDX_DATA:  rmux = rx_data_i;
            IDX_DIVLO: rmux = divisor_o[WORD_W-1:0];
            IDX_DIVHI: rmux = div_hi_word;
            default:   rmux = '0;
        endcase
    end

    // data-port side effects and read data, aligned with ack
    typedef struct packed {
        logic [WORD_W-1:0] rdat;
        logic [WORD_W-1:0] txd;
        logic              pop;
        logic              push;
    } port_st_t;

    port_st_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.pop  = 1'b0;
        p_d.push = 1'b0;
        if (take) begin
            if (wb_we_i) begin
                if (wb_adr_i == IDX_DATA) begin
                    p_d.push = 1'b1;
                    p_d.txd  = wb_dat_i;
                end
            end else begin
                p_d.rdat = rmux;
                p_d.pop  = (wb_adr_i == IDX_DATA);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) p_q <= '0;
        else       p_q <= p_d;
    end

    assign wb_dat_o      = p_q.rdat;
    assign tx_data_o     = p_q.txd;
    assign rx_pop_o      = p_q.pop;
    assign tx_push_o     = p_q.push;
    assign frame_len_o   = cfg.frame_len;
    assign rxc_edge_en_o = cfg.rxc_edge_en;
    assign rxd_edge_en_o = cfg.rxd_edge_en;
    assign txc_mode_o    = cfg.txc_mode;
    assign rxc_pol_o     = cfg.rxc_pol;

    AST_POP_WITH_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_pop_o |-> wb_ack_o); // R7
    AST_PUSH_WITH_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_push_o |-> (wb_ack_o && $past(wb_we_i))); // R8
    AST_SUMMARY_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (wb_ack_o && $past(!wb_we_i && wb_adr_i == IDX_STAT))
        |-> (wb_dat_o[WORD_W-1] == (|wb_dat_o[FLAG_W-1:0]))); // R4
    AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (wb_ack_o && $past(!wb_we_i && (wb_adr_i == IDX_RSV0 || wb_adr_i == IDX_RSV1)))
        |-> (wb_dat_o == '0)); // R9
    AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(divisor_o) |-> wb_ack_o); // R10
    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(cfg) |-> wb_ack_o); // R2

endmodule

// File: tb/serial_csr_bench.sv
`timescale 1ns/1ps
module serial_csr_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [2:0]  adr = '0;
    logic [15:0] wdat = '0;
    logic [15:0] rdat;
    logic        ack;
    logic [3:0]  flags = '0;
    logic [15:0] rxd = '0;
    logic        pop, push, rxce, rxde, rxcp, irq;
    logic [15:0] txd;
    logic [4:0]  flen;
    logic [2:0]  txm;
    logic [19:0] divv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [15:0] m_cfg  = '0;
    logic [3:0]  m_mask = '0;
    logic [19:0] m_div  = '0;

    always #10 clk = ~clk;

    serial_csr u_serial_csr (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .fifo_flags_i(flags), .rx_data_i(rxd), .rx_pop_o(pop),
        .tx_data_o(txd), .tx_push_o(push), .frame_len_o(flen),
        .rxc_edge_en_o(rxce), .rxd_edge_en_o(rxde), .txc_mode_o(txm),
        .rxc_pol_o(rxcp), .divisor_o(divv), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [2:0] i);
        case (i)
            3'd0: return m_cfg & 16'h3F1F;
            3'd1: return {(|flags), 11'b0, flags};
            3'd2: return {12'b0, m_mask};
            3'd3: return rxd;
            3'd6: return m_div[15:0];
            3'd7: return {12'b0, m_div[19:16]};
            default: return 16'h0000;
        endcase
    endfunction

    // compared on every clock, at the falling edge
    task automatic check_all(bit in_ack);
        chk("R1 ack", ack, in_ack);
        if (!in_ack) begin
            chk("R7 pop idle", pop, 0);
            chk("R8 push idle", push, 0);
        end
        chk("R6 irq", irq, |(flags & m_mask));
        chk("R2 frame_len", flen, m_cfg[4:0]);
        chk("R2 rxc_edge", rxce, m_cfg[8]);
        chk("R2 rxd_edge", rxde, m_cfg[9]);
        chk("R2 txc_mode", txm, m_cfg[12:10]);
        chk("R2 rxc_pol", rxcp, m_cfg[13]);
        chk("R10 divisor", divv, m_div);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_all(0);
    endtask

    task automatic wb_write(logic [2:0] i, logic [15:0] d, bit hold);
        cyc = 1; stb = 1; we = 1; adr = i; wdat = d;
        @(posedge clk);
        case (i)
            3'd0: m_cfg = d;
            3'd2: m_mask = d[3:0];
            3'd6: m_div[15:0] = d;
            3'd7: m_div[19:16] = d[3:0];
            default: ;
        endcase
        @(negedge clk);
        check_all(1);
        chk("R12 no pop on write", pop, 0);
        if (i == 3'd3) begin
            chk("R8 push", push, 1);
            chk("R8 tx data", txd, d);
        end else begin
            chk("R12 no push", push, 0);
        end
        if (hold) begin
            @(posedge clk);
            @(negedge clk);
            check_all(0);
        end
        cyc = 0; stb = 0; we = 0;
        step();
    endtask

    task automatic wb_read(logic [2:0] i, bit hold);
        logic [15:0] e;
        cyc = 1; stb = 1; we = 0; adr = i;
        @(posedge clk);
        e = exp_read(i);
        @(negedge clk);
        check_all(1);
        chk("R3/R5/R9/R10 read data", rdat, e);
        chk("R7 pop on data read", pop, (i == 3'd3));
        chk("R12 no push on read", push, 0);
        if (hold) begin
            @(posedge clk);
            @(negedge clk);
            check_all(0);
        end
        cyc = 0; stb = 0;
        step();
    endtask

    task automatic read_all();
        for (int k = 0; k < 8; k++) wb_read(3'(k), 0);
    endtask

    initial begin
        // R11: state while held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(0);
        rst = 0;
        step();
        read_all(); // R11 reset values

        // R2 configuration fields, unused bits read zero
        wb_write(3'd0, 16'hFFFF, 0);
        wb_read(3'd0, 0);
        wb_write(3'd0, 16'h2A15, 0);
        wb_read(3'd0, 0);
        wb_write(3'd0, 16'h1500, 0);
        wb_read(3'd0, 0);

        // R5 mask, R3/R4 status over flag patterns, R6 irq
        wb_write(3'd2, 16'hFFF5, 0);
        wb_read(3'd2, 0);
        for (int p = 0; p < 16; p++) begin
            flags = 4'(p);
            step();
            wb_read(3'd1, 0);
        end
        wb_write(3'd2, 16'h0000, 0);
        for (int b = 0; b < 4; b++) begin
            flags = 4'hF ^ (4'b1 << b);
            wb_write(3'd2, 16'(1 << b), 0);
            step();
            flags = 4'hF;
            step();
        end

        // R7 receive data and pop; R8 transmit push
        rxd = 16'h1234;
        wb_read(3'd3, 0);
        rxd = 16'hCAFE;
        wb_read(3'd3, 1); // strobe held: one ack, one pop (R1, R7)
        wb_write(3'd3, 16'hA5C3, 0);
        wb_write(3'd3, 16'h5A3C, 1); // strobe held: one push (R8)
        wb_read(3'd0, 1); // R1 held strobe on a plain register

        // R10 divisor halves
        wb_write(3'd6, 16'hBEEF, 0);
        wb_write(3'd7, 16'hFFFF, 0);
        wb_read(3'd6, 0);
        wb_read(3'd7, 0);

        // R9 / R12: writes to unused and read-only words change nothing
        wb_write(3'd4, 16'hFFFF, 0);
        wb_write(3'd5, 16'hFFFF, 0);
        wb_write(3'd1, 16'hFFFF, 0);
        flags = 4'b0000;
        step();
        read_all();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule